// File: doc/BRIEF.md
# Interrupt Deferral Across a Busy Window

This block sits between a chip's interrupt sources and the processor's dispatch logic. It stops dispatch while a busy window is open, for example while on-chip code is being loaded. When the window closes it decides which requests are still valid and offers the most urgent one. Four kinds of source feed it:

- a non-maskable request;
- a debug-class request;
- a set of active-low external pins, each configured for falling-edge or low-level sensing;
- a set of active-high peripheral level requests.

Edge-type requests are captured and survive the window. A level-sensed pin is only looked at again when the window ends, and it is dropped if it has returned high by then.

The dispatch side is a valid/ready stream carrying a source index. An offer keeps its index stable until `irq_ready_i` is seen high with `irq_valid_o`. That handshake retires the source. Back-pressure is unlimited: the offer waits for ready for as long as needed. The one thing that withdraws an offer without a handshake is the busy window opening. In that case the source is not retired, and it competes again when the window closes. Level sources (low-level pins and peripherals) are expected to go inactive before their offer is acknowledged; otherwise they are offered again.

Top module: `irq_defer`

## Requirements
- R1: While `busy_i` is sampled high no offer is made; an offer already showing is withdrawn at the first edge where `busy_i` is high, without retiring its source, and is offered again once `busy_i` is low.
- R2: A non-maskable request (index 0) or debug request (index 1) that is high at a clock edge is captured and stays pending, through any busy window, until a handshake carries its index.
- R3: External pins are active low and pass through `SYNC_STAGES` (default 2) synchroniser flops that reset to high; `ext_mode_i[k]` = 1 selects falling-edge sensing for pin k, 0 selects low-level sensing; pin k has index 2+k.
- R4: In falling-edge mode a high-to-low transition of the synchronised pin is captured and stays pending, through any busy window and regardless of the pin's later level, until a handshake carries its index.
- R5: In low-level mode a pin is pending only while its synchronised level is low; a pin that went low during a window and is high again when the window ends is never offered.
- R6: Peripheral request j (active high, index 2+N_EXT+j) is pending exactly while its input is high.
- R7: Priority is fixed: the lowest pending index is offered, so non-maskable beats debug, debug beats pins, and pins and peripherals rank by their own index.
- R8: `irq_valid_o` is low after reset; while valid is high and ready is low (and busy low) the offer and its index stay unchanged; at a handshake the acknowledged source is left out of the next pick, so a still-high level source returns only one cycle later.
- R9: With the window closed and nothing pending, the first offer appears 1 edge after a peripheral input rises, 2 edges after a non-maskable or debug pulse, SYNC_STAGES+1 edges after a low-level pin falls, and SYNC_STAGES+2 edges after an edge-mode pin falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Busy window; high holds back all dispatch |
| nmi_i | input | 1 | Non-maskable request, captured when high |
| dbg_i | input | 1 | Debug-class request, captured when high |
| ext_n_i | input | N_EXT | External request pins, active low |
| ext_mode_i | input | N_EXT | Per-pin sensing: 1 falling edge, 0 low level |
| per_i | input | N_PER | Peripheral level requests, active high |
| irq_valid_o | output | 1 | An offer is present |
| irq_idx_o | output | IDX_W | Index of the offered source |
| irq_ready_i | input | 1 | Dispatcher accepts the offer |

## Verification
The cost of each source in edges follows from the registers on its path. A peripheral level is one output register away. A non-maskable or debug pulse adds its capture flop. A low-level pin adds the synchroniser. An edge-mode pin adds the synchroniser and the edge capture. The directed latency checks step one edge at a time, sampling on the falling clock edge. They expect no offer at every earlier edge and the offer exactly at the due edge. The random windows compare each offer with a bench model of the pending set only after the offer has had time to settle. This is safe because an offer is held until acknowledged. Before acknowledging, the bench lets several edges pass to confirm the held index, which also leaves time for a released level source to clear the synchroniser.

// File: rtl/irq_defer_pkg.sv
package irq_defer_pkg;
  // sensing choice per external pin
  typedef enum logic {
    SENSE_LOW  = 1'b0,
    SENSE_FALL = 1'b1
  } irq_sense_e;

  // fixed index layout: lower index means higher priority
  localparam int unsigned IDX_NMI  = 0;
  localparam int unsigned IDX_DBG  = 1;
  localparam int unsigned EXT_BASE = 2;
endpackage

// File: rtl/irq_defer_pin.sv
module irq_defer_pin #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_i,
  output logic low_o,
  output logic fall_o
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] shift_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      shift_q <= {shift_q[SYNC_STAGES-2:0], pin_n_i};
      prev_q  <= shift_q[MSB];
    end
  end

  assign low_o  = ~shift_q[MSB];
  assign fall_o = prev_q & ~shift_q[MSB];
endmodule

// File: rtl/irq_defer_pend.sv
module irq_defer_pend
  import irq_defer_pkg::*;
#(
  parameter int unsigned N_EXT       = 4,
  parameter int unsigned N_PER       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned N_SRC      = 2 + N_EXT + N_PER,
  localparam int unsigned IDX_W      = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_i,
  input  logic             dbg_i,
  input  logic [N_EXT-1:0] ext_n_i,
  input  logic [N_EXT-1:0] ext_mode_i,
  input  logic [N_PER-1:0] per_i,
  input  logic             ack_vld_i,
  input  logic [IDX_W-1:0] ack_idx_i,
  output logic [N_SRC-1:0] pend_o
);
  localparam int unsigned PER_BASE = EXT_BASE + N_EXT;

  logic [N_SRC-1:0] ack_hot;
  logic             nmi_q, dbg_q;
  logic [N_EXT-1:0] pin_low, pin_fall, edge_q;

  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      ack_hot[i] = ack_vld_i && (ack_idx_i == IDX_W'(i));
    end
  end

  // captured one-shot requests: a new request wins over a same-cycle retire
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q <= 1'b0;
      dbg_q <= 1'b0;
    end else begin
      nmi_q <= nmi_i | (nmi_q & ~ack_hot[IDX_NMI]);
      dbg_q <= dbg_i | (dbg_q & ~ack_hot[IDX_DBG]);
    end
  end

  p_nmi_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_q && !ack_hot[IDX_NMI] |=> nmi_q);
  p_dbg_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_q && !ack_hot[IDX_DBG] |=> dbg_q);

  for (genvar k = 0; k < N_EXT; k++) begin : g_pin
    irq_defer_pin #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_n_i(ext_n_i[k]),
      .low_o  (pin_low[k]),
      .fall_o (pin_fall[k])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        edge_q[k] <= 1'b0;
      end else if (ext_mode_i[k] == SENSE_FALL) begin
        edge_q[k] <= pin_fall[k] | (edge_q[k] & ~ack_hot[EXT_BASE+k]);
      end else begin
        edge_q[k] <= 1'b0;
      end
    end

    assign pend_o[EXT_BASE+k] = (ext_mode_i[k] == SENSE_FALL) ? edge_q[k] : pin_low[k];

    p_fall_caught_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pin_fall[k] && ext_mode_i[k] && $stable(ext_mode_i[k]) |=> edge_q[k]);
    p_edge_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      edge_q[k] && ext_mode_i[k] && !ack_hot[EXT_BASE+k] && $stable(ext_mode_i[k])
      |=> edge_q[k]);
  end

  assign pend_o[IDX_NMI] = nmi_q;
  assign pend_o[IDX_DBG] = dbg_q;
  assign pend_o[PER_BASE +: N_PER] = per_i;
endmodule

// File: rtl/irq_defer_arb.sv
module irq_defer_arb #(
  parameter int unsigned N_SRC  = 14,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_defer.sv
module irq_defer
  import irq_defer_pkg::*;
#(
  parameter int unsigned N_EXT       = 4,
  parameter int unsigned N_PER       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned N_SRC      = 2 + N_EXT + N_PER,
  localparam int unsigned IDX_W      = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy_i,
  input  logic             nmi_i,
  input  logic             dbg_i,
  input  logic [N_EXT-1:0] ext_n_i,
  input  logic [N_EXT-1:0] ext_mode_i,
  input  logic [N_PER-1:0] per_i,
  output logic             irq_valid_o,
  output logic [IDX_W-1:0] irq_idx_o,
  input  logic             irq_ready_i
);
  logic [N_SRC-1:0] pend, hs_hot, cand;
  logic             hs, load, pick_any;
  logic [IDX_W-1:0] pick_idx;
  logic             out_vld;
  logic [IDX_W-1:0] out_idx;

  assign hs   = out_vld & irq_ready_i;
  assign load = !busy_i && (!out_vld || hs);

  irq_defer_pend #(
    .N_EXT(N_EXT), .N_PER(N_PER), .SYNC_STAGES(SYNC_STAGES)
  ) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .nmi_i     (nmi_i),
    .dbg_i     (dbg_i),
    .ext_n_i   (ext_n_i),
    .ext_mode_i(ext_mode_i),
    .per_i     (per_i),
    .ack_vld_i (hs),
    .ack_idx_i (out_idx),
    .pend_o    (pend)
  );

  // the source retired at this edge must not be picked again at the same edge
  always_comb begin
    for (int i = 0; i < N_SRC; i++) begin
      hs_hot[i] = hs && (out_idx == IDX_W'(i));
    end
  end
  assign cand = pend & ~hs_hot;

  irq_defer_arb #(.N_SRC(N_SRC)) u_arb (
    .req_i(cand),
    .any_o(pick_any),
    .idx_o(pick_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_idx <= '0;
    end else if (busy_i) begin
      out_vld <= 1'b0;
    end else if (load) begin
      out_vld <= pick_any;
      if (pick_any) out_idx <= pick_idx;
    end
  end

  assign irq_valid_o = out_vld;
  assign irq_idx_o   = out_idx;

  p_quiet_in_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> !irq_valid_o);
  p_offer_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o && !irq_ready_i && !busy_i |=> irq_valid_o && $stable(irq_idx_o));
  p_nmi_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load && pend[IDX_NMI] && !hs_hot[IDX_NMI] |=> irq_valid_o && (irq_idx_o == '0));
  p_retired_skipped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hs && !busy_i |=> !(irq_valid_o && irq_idx_o == $past(irq_idx_o)));
endmodule

// File: tb/test_irq_defer.sv
`timescale 1ns/1ps
module test_irq_defer;
  localparam int N_EXT = 4;
  localparam int N_PER = 8;
  localparam int SYNC  = 2;
  localparam int N_SRC = 2 + N_EXT + N_PER;
  localparam int IDX_W = $clog2(N_SRC);
  localparam int PER_BASE = 2 + N_EXT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic busy_i = 1'b0, nmi_i = 1'b0, dbg_i = 1'b0, irq_ready_i = 1'b0;
  logic [N_EXT-1:0] ext_n_i = '1;
  logic [N_EXT-1:0] ext_mode_i = '0;
  logic [N_PER-1:0] per_i = '0;
  logic irq_valid_o;
  logic [IDX_W-1:0] irq_idx_o;

  int checks = 0;
  int errors = 0;
  logic [N_SRC-1:0] model;

  always #2.5 clk = ~clk;

  irq_defer #(.N_EXT(N_EXT), .N_PER(N_PER), .SYNC_STAGES(SYNC)) i_irq_defer (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .nmi_i(nmi_i), .dbg_i(dbg_i),
    .ext_n_i(ext_n_i), .ext_mode_i(ext_mode_i), .per_i(per_i),
    .irq_valid_o(irq_valid_o), .irq_idx_o(irq_idx_o), .irq_ready_i(irq_ready_i)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic handshake();
    irq_ready_i = 1'b1;
    step();
    irq_ready_i = 1'b0;
  endtask

  function automatic int first_set(input logic [N_SRC-1:0] m);
    for (int i = 0; i < N_SRC; i++) if (m[i]) return i;
    return -1;
  endfunction

  // offer expected exactly at edge 'due', absent before it
  task automatic expect_at(input int due, input int idx, input string req);
    for (int e = 1; e <= due; e++) begin
      step();
      if (e < due) check(!irq_valid_o, req, int'(irq_valid_o), 0);
      else check(irq_valid_o && irq_idx_o == IDX_W'(idx), req, int'(irq_idx_o), idx);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R8 reset state
    check(!irq_valid_o, "R8 reset", int'(irq_valid_o), 0);

    // R6 R9: peripheral 3 due after one edge
    per_i[3] = 1'b1;
    expect_at(1, PER_BASE + 3, "R9 R6 peripheral latency");
    // R8: still high at handshake -> gap of one cycle, then offered again
    handshake();
    check(!irq_valid_o, "R8 retired skipped", int'(irq_valid_o), 0);
    step();
    check(irq_valid_o && irq_idx_o == IDX_W'(PER_BASE + 3), "R8 level returns", int'(irq_idx_o), PER_BASE + 3);
    // R1: window opens over a held offer, then closes
    busy_i = 1'b1;
    step();
    check(!irq_valid_o, "R1 withdrawn", int'(irq_valid_o), 0);
    busy_i = 1'b0;
    step();
    check(irq_valid_o && irq_idx_o == IDX_W'(PER_BASE + 3), "R1 re-offered", int'(irq_idx_o), PER_BASE + 3);
    per_i[3] = 1'b0;
    step();
    handshake();
    repeat (2) step();
    check(!irq_valid_o, "R6 cleared", int'(irq_valid_o), 0);

    // R2 R9: non-maskable pulse due after two edges
    nmi_i = 1'b1;
    step();
    nmi_i = 1'b0;
    check(!irq_valid_o, "R9 nmi edge1", int'(irq_valid_o), 0);
    expect_at(1, 0, "R9 R2 nmi latency");
    handshake();
    repeat (2) step();
    check(!irq_valid_o, "R2 retired", int'(irq_valid_o), 0);

    // R5 R9: low-level pin due after SYNC+1 edges
    ext_mode_i = '0;
    ext_n_i[1] = 1'b0;
    expect_at(SYNC + 1, 3, "R9 R5 level latency");
    ext_n_i[1] = 1'b1;
    repeat (SYNC + 2) step();
    handshake();
    repeat (3) step();
    check(!irq_valid_o, "R5 released", int'(irq_valid_o), 0);

    // R4 R9: edge-mode pin due after SYNC+2 edges
    ext_mode_i[2] = 1'b1;
    repeat (3) step();
    ext_n_i[2] = 1'b0;
    expect_at(SYNC + 2, 4, "R9 R4 edge latency");
    ext_n_i[2] = 1'b1;
    repeat (4) step();
    handshake();
    repeat (4) step();
    check(!irq_valid_o, "R4 retired", int'(irq_valid_o), 0);

    // R5: level pin low only inside the window is cancelled
    ext_mode_i = '0;
    repeat (3) step();
    busy_i = 1'b1;
    ext_n_i[0] = 1'b0;
    repeat (4) step();
    ext_n_i[0] = 1'b1;
    repeat (SYNC + 2) step();
    busy_i = 1'b0;
    repeat (6) step();
    check(!irq_valid_o, "R5 cancelled", int'(irq_valid_o), 0);

    // random windows
    for (int it = 0; it < 60; it++) begin
      model = '0;
      ext_mode_i = N_EXT'($urandom);
      repeat (SYNC + 2) step();
      busy_i = 1'b1;
      step();
      if ($urandom_range(1, 0) == 1) begin nmi_i = 1'b1; model[0] = 1'b1; end
      if ($urandom_range(1, 0) == 1) begin dbg_i = 1'b1; model[1] = 1'b1; end
      for (int k = 0; k < N_EXT; k++) if ($urandom_range(1, 0) == 1) ext_n_i[k] = 1'b0;
      step();
      nmi_i = 1'b0;
      dbg_i = 1'b0;
      for (int j = 0; j < N_PER; j++) begin
        per_i[j] = ($urandom_range(2, 0) == 0);
        model[PER_BASE + j] = per_i[j];
      end
      repeat (SYNC + 1) begin
        step();
        check(!irq_valid_o, "R1 window", int'(irq_valid_o), 0);
      end
      for (int k = 0; k < N_EXT; k++) begin
        if (!ext_n_i[k]) begin
          if (ext_mode_i[k]) model[2 + k] = 1'b1;   // R4 kept
          if ($urandom_range(1, 0) == 1) ext_n_i[k] = 1'b1;
          if (!ext_mode_i[k] && !ext_n_i[k]) model[2 + k] = 1'b1;  // R5 resampled
        end
      end
      repeat (SYNC + 2) begin
        step();
        check(!irq_valid_o, "R1 window", int'(irq_valid_o), 0);
      end
      busy_i = 1'b0;
      for (int n = 0; n <= N_SRC; n++) begin
        int e;
        int w;
        int got;
        e = first_set(model);
        w = 0;
        while (!irq_valid_o && w < 12) begin step(); w++; end
        if (e < 0) begin
          check(!irq_valid_o, "R7 drained", int'(irq_valid_o), 0);
          break;
        end
        check(irq_valid_o && irq_idx_o == IDX_W'(e), "R7 order", int'(irq_idx_o), e);
        if (!irq_valid_o) break;
        got = int'(irq_idx_o);
        if (got >= PER_BASE) per_i[got - PER_BASE] = 1'b0;
        else if (got >= 2 && !ext_mode_i[got - 2]) ext_n_i[got - 2] = 1'b1;
        repeat (4) step();
        check(irq_valid_o && irq_idx_o == IDX_W'(got), "R8 held", int'(irq_idx_o), got);
        handshake();
        model[got] = 1'b0;
      end
      ext_n_i = '1;
      per_i = '0;
      repeat (SYNC + 3) step();
      check(!irq_valid_o, "R3 idle", int'(irq_valid_o), 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule